// File: doc/BRIEF.md
# Partial-Width General-Purpose Register File

This block holds sixteen 64-bit architectural registers and serves two combinational read ports and one synchronous write port. Every port carries a 4-bit register index, a 2-bit operand size (0 = byte, 1 = word, 2 = doubleword, 3 = quadword) and an extension flag. The block applies the sub-register rules of the architecture itself. Narrow writes merge into the old contents, and a doubleword write clears the upper half. Read results come back right-justified and zero-extended.

Byte operands decode in one of two ways. When the extension flag is set, byte index n names bits 7:0 of register n, for all sixteen registers. When the flag is clear, byte indices 4 to 7 name the second byte of the first four registers. Registers 8 to 15 can only be reached with the flag set. An access that breaks this rule raises an illegal flag on its port, and an illegal write changes nothing.

Top module: `gpr_subreg_file`

## Requirements
- R1: A synchronous active-low reset clears all sixteen registers to zero, so every read after reset returns 0.
- R2: A quadword write (size 3) replaces all 64 bits of the target register.
- R3: A doubleword write (size 2) stores bits 31:0 of the write data and sets bits 63:32 of the register to zero.
- R4: A word write (size 1) replaces bits 15:0 and leaves bits 63:16 unchanged.
- R5: A byte write to a low byte replaces bits 7:0 and leaves bits 63:8 unchanged.
- R6: When the extension flag is clear, byte indices 4, 5, 6 and 7 select bits 15:8 of registers 0, 3, 1 and 2 respectively, for both reads and writes. A write to such a byte leaves every other bit of the register unchanged.
- R7: When the extension flag is set, byte index n selects bits 7:0 of register n for every n from 0 to 15.
- R8: Read data is right-justified and zero-extended to 64 bits. A byte read of bits 15:8 returns them in bits 7:0.
- R9: Any access with index 8 or above while the extension flag is clear raises that port's illegal output in the same cycle. A write flagged this way leaves every register unchanged.
- R10: A read of the register being written in the same cycle returns the value from before the write. The new value appears from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write operand size |
| wr_ext | input | 1 | Write extension flag |
| wr_data | input | 64 | Write data, right-justified |
| wr_illegal | output | 1 | Write request is illegal and is dropped |
| ra_idx | input | 4 | Read port A index |
| ra_size | input | 2 | Read port A size |
| ra_ext | input | 1 | Read port A extension flag |
| ra_data | output | 64 | Read port A data |
| ra_illegal | output | 1 | Read port A access is illegal |
| rb_idx | input | 4 | Read port B index |
| rb_size | input | 2 | Read port B size |
| rb_ext | input | 1 | Read port B extension flag |
| rb_data | output | 64 | Read port B data |
| rb_illegal | output | 1 | Read port B access is illegal |

## Verification
All state sits in the register array, so a wrong merge, clear or byte decode stays hidden until a read touches the damaged bits. The bench reads every register at quadword size after each write. A corrupted bit, whether above or below the written field, then shows up in the cycle after the faulty write. Alias errors in the byte decode show as data on the wrong register, or on the wrong byte of the right one.

// File: rtl/gpr_subreg_pkg.sv
// Package: shared types and constants for the partial-width register file.
// Assumes the size codes are fixed by the instruction encoding: 0 byte, 1 word,
// 2 doubleword, 3 quadword.
package gpr_subreg_pkg;
    parameter int DATA_W = 64;
    parameter int NREGS  = 16;
    parameter int IDX_W  = $clog2(NREGS);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_QWORD = 2'd3
    } op_size_e;

    // Resolved operand: physical register, whether it is the second byte, and legality.
    typedef struct packed {
        logic [IDX_W-1:0] reg_idx;
        logic             hi_byte;
        logic             illegal;
    } operand_t;
endpackage

// File: rtl/gpr_operand_decode.sv
// Module: maps an architectural index, size and extension flag to a physical
// register, a high-byte select and an illegal flag. Assumes the unprefixed
// high-byte aliases 4..7 map to registers 0, 3, 1, 2.
module gpr_operand_decode
    import gpr_subreg_pkg::*;
#(
    parameter int NR = NREGS,
    localparam int IW = $clog2(NR)
) (
    input  logic [IW-1:0] idx,
    input  logic [1:0]    size,
    input  logic          ext,
    output operand_t      opnd
);
    localparam int LEGACY = NR / 2;

    // Resolve the alias and legality of one operand.
    always_comb begin
        opnd.reg_idx = idx;
        opnd.hi_byte = 1'b0;
        opnd.illegal = !ext && (int'(idx) >= LEGACY);
        if (!ext && size == SZ_BYTE && idx >= IW'(4) && idx <= IW'(7)) begin
            opnd.hi_byte = 1'b1;
            case (idx[1:0])
                2'd0:    opnd.reg_idx = IW'(0);
                2'd1:    opnd.reg_idx = IW'(3);
                2'd2:    opnd.reg_idx = IW'(1);
                default: opnd.reg_idx = IW'(2);
            endcase
        end
    end
endmodule

// File: rtl/gpr_read_format.sv
// Module: extracts the addressed field of a full register and returns it
// right-justified and zero-extended. Assumes a resolved operand on its input.
module gpr_read_format
    import gpr_subreg_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] full,
    input  logic [1:0]   size,
    input  logic         hi_byte,
    output logic [W-1:0] data
);
    // Select and zero-extend the addressed field.
    always_comb begin
        data = '0;
        case (size)
            SZ_BYTE:  data[7:0]  = hi_byte ? full[15:8] : full[7:0];
            SZ_WORD:  data[15:0] = full[15:0];
            SZ_DWORD: data[31:0] = full[31:0];
            default:  data       = full;
        endcase
    end
endmodule

// File: rtl/gpr_write_merge.sv
// Module: computes the new register value for a write of a given size.
// Narrow writes merge, and a doubleword write zero-extends. Assumes W >= 32.
module gpr_write_merge
    import gpr_subreg_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] wdata,
    input  logic [1:0]   size,
    input  logic         hi_byte,
    output logic [W-1:0] new_val
);
    // Build the merged or zero-extended register image.
    always_comb begin
        new_val = old_val;
        case (size)
            SZ_BYTE: begin
                if (hi_byte) new_val[15:8] = wdata[7:0];
                else         new_val[7:0]  = wdata[7:0];
            end
            SZ_WORD:  new_val[15:0] = wdata[15:0];
            SZ_DWORD: new_val = {{(W-32){1'b0}}, wdata[31:0]};
            default:  new_val = wdata;
        endcase
    end
endmodule

// File: rtl/gpr_subreg_file.sv
// Module: top of the 16 x 64 register file with two read ports and one write
// port. Reads are combinational and see pre-write state (no bypass). Reset is
// synchronous, active-low.
module gpr_subreg_file
    import gpr_subreg_pkg::*;
#(
    parameter int NR = NREGS,
    parameter int W  = DATA_W,
    localparam int IW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [1:0]    wr_size,
    input  logic          wr_ext,
    input  logic [W-1:0]  wr_data,
    output logic          wr_illegal,
    input  logic [IW-1:0] ra_idx,
    input  logic [1:0]    ra_size,
    input  logic          ra_ext,
    output logic [W-1:0]  ra_data,
    output logic          ra_illegal,
    input  logic [IW-1:0] rb_idx,
    input  logic [1:0]    rb_size,
    input  logic          rb_ext,
    output logic [W-1:0]  rb_data,
    output logic          rb_illegal
);
    localparam int NPORT = 3;

    logic [W-1:0]  regs [NR];
    logic [IW-1:0] p_idx  [NPORT];
    logic [1:0]    p_size [NPORT];
    logic          p_ext  [NPORT];
    operand_t      p_op   [NPORT];
    logic [W-1:0]  merged;

    assign p_idx[0] = wr_idx;  assign p_size[0] = wr_size; assign p_ext[0] = wr_ext;
    assign p_idx[1] = ra_idx;  assign p_size[1] = ra_size; assign p_ext[1] = ra_ext;
    assign p_idx[2] = rb_idx;  assign p_size[2] = rb_size; assign p_ext[2] = rb_ext;

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        gpr_operand_decode #(.NR(NR)) u_dec (
            .idx(p_idx[p]), .size(p_size[p]), .ext(p_ext[p]), .opnd(p_op[p])
        );
    end

    gpr_read_format #(.W(W)) u_fmt_a (
        .full(regs[p_op[1].reg_idx]), .size(ra_size),
        .hi_byte(p_op[1].hi_byte), .data(ra_data)
    );
    gpr_read_format #(.W(W)) u_fmt_b (
        .full(regs[p_op[2].reg_idx]), .size(rb_size),
        .hi_byte(p_op[2].hi_byte), .data(rb_data)
    );
    gpr_write_merge #(.W(W)) u_merge (
        .old_val(regs[p_op[0].reg_idx]), .wdata(wr_data), .size(wr_size),
        .hi_byte(p_op[0].hi_byte), .new_val(merged)
    );

    assign wr_illegal = p_op[0].illegal;
    assign ra_illegal = p_op[1].illegal;
    assign rb_illegal = p_op[2].illegal;

    // Register array: clear on reset, otherwise commit one legal write.
    for (genvar r = 0; r < NR; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[r] <= '0;
            else if (wr_en && !p_op[0].illegal && p_op[0].reg_idx == IW'(r))
                regs[r] <= merged;
        end
    end
endmodule

// File: rtl/gpr_subreg_file_chk.sv
// Checker: port-level properties of gpr_subreg_file, attached by bind.
module gpr_subreg_file_chk #(
    parameter int W = 64,
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [IW-1:0] wr_idx,
    input logic [1:0]    wr_size,
    input logic          wr_ext,
    input logic [W-1:0]  wr_data,
    input logic          wr_illegal,
    input logic [IW-1:0] ra_idx,
    input logic [1:0]    ra_size,
    input logic          ra_ext,
    input logic [W-1:0]  ra_data,
    input logic          ra_illegal
);
    // R9
    always_ff @(posedge clk) begin
        if (rst_n) begin
            illegal_flag_chk: assert (ra_illegal == (!ra_ext && ra_idx[IW-1]));
        end
    end

    // R8
    read_zext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ra_size == 2'd0 |-> ra_data[W-1:8] == '0);

    // R8
    read_zext_dword_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ra_size == 2'd2 |-> ra_data[W-1:32] == '0);

    // R3
    dword_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_illegal && wr_size == 2'd2 && ra_size == 2'd3 &&
         ra_ext && ra_idx == wr_idx && wr_ext)
        |=> ($past(ra_size) != 2'd3 || !$stable(ra_idx) || !$stable(ra_ext) ||
             !$stable(ra_size) || !rst_n || ra_data[W-1:32] == '0));

    // R2
    qword_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ext && wr_size == 2'd3 && ra_ext && ra_size == 2'd3 &&
         ra_idx == wr_idx)
        |=> (!$stable(ra_idx) || !$stable(ra_size) || !$stable(ra_ext) ||
             (wr_en && wr_idx == ra_idx) || ra_data == $past(wr_data)));
endmodule

bind gpr_subreg_file gpr_subreg_file_chk #(.W(W), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_ext(wr_ext), .wr_data(wr_data), .wr_illegal(wr_illegal),
    .ra_idx(ra_idx), .ra_size(ra_size), .ra_ext(ra_ext), .ra_data(ra_data),
    .ra_illegal(ra_illegal)
);

// File: tb/gpr_subreg_file_bench.sv
module gpr_subreg_file_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [1:0]  wr_size;
    logic        wr_ext;
    logic [63:0] wr_data;
    logic        wr_illegal;
    logic [3:0]  ra_idx, rb_idx;
    logic [1:0]  ra_size, rb_size;
    logic        ra_ext, rb_ext;
    logic [63:0] ra_data, rb_data;
    logic        ra_illegal, rb_illegal;

    int checks = 0;
    int errors = 0;
    longint unsigned model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpr_subreg_file u_gpr_subreg_file (.*);

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: resolve alias behaviourally.
    function automatic int phys(input int idx, input int size, input bit ext, output bit hi);
        hi = 0;
        if (!ext && size == 0 && idx >= 4 && idx <= 7) begin
            hi = 1;
            case (idx)
                4: return 0;
                5: return 3;
                6: return 1;
                default: return 2;
            endcase
        end
        return idx;
    endfunction

    function automatic longint unsigned ref_read(input int idx, input int size, input bit ext);
        bit hi; int p; longint unsigned v;
        p = phys(idx, size, ext, hi);
        v = model[p];
        case (size)
            0: return hi ? ((v >> 8) & 64'hFF) : (v & 64'hFF);
            1: return v & 64'hFFFF;
            2: return v & 64'hFFFF_FFFF;
            default: return v;
        endcase
    endfunction

    function automatic void ref_write(input int idx, input int size, input bit ext, input longint unsigned d);
        bit hi; int p;
        if (!ext && idx >= 8) return;
        p = phys(idx, size, ext, hi);
        case (size)
            0: if (hi) model[p] = (model[p] & ~64'hFF00) | ((d & 64'hFF) << 8);
               else    model[p] = (model[p] & ~64'hFF) | (d & 64'hFF);
            1: model[p] = (model[p] & ~64'hFFFF) | (d & 64'hFFFF);
            2: model[p] = d & 64'hFFFF_FFFF;
            default: model[p] = d;
        endcase
    endfunction

    // Compare every register at quadword size via port B (R1..R7, R9 suppression)
    task automatic sweep(input string req);
        for (int i = 0; i < 16; i++) begin
            rb_idx = 4'(i); rb_size = 2'd3; rb_ext = 1'b1;
            #1;
            check64(req, rb_data, model[i]);
        end
    endtask

    // One write cycle; port A reads same register to observe no-bypass (R10).
    task automatic do_write(input string req, input int idx, input int size, input bit ext,
                            input longint unsigned d);
        longint unsigned before_v;
        wr_en = 1; wr_idx = 4'(idx); wr_size = 2'(size); wr_ext = ext; wr_data = d;
        ra_idx = 4'(idx); ra_size = 2'(size); ra_ext = ext;
        #1;
        check64("R9 wr_illegal", {63'd0, wr_illegal}, {63'd0, (!ext && idx >= 8)});
        before_v = ref_read(idx, size, ext);
        if (!(!ext && idx >= 8)) check64("R10 old value", ra_data, before_v);
        @(posedge clk); #2;
        ref_write(idx, size, ext, d);
        wr_en = 0;
        sweep(req);
    endtask

    initial begin
        rst_n = 0; wr_en = 0; wr_idx = 0; wr_size = 0; wr_ext = 0; wr_data = 0;
        ra_idx = 0; ra_size = 3; ra_ext = 1; rb_idx = 0; rb_size = 3; rb_ext = 1;
        for (int i = 0; i < 16; i++) model[i] = 64'h0;
        @(posedge clk); @(posedge clk); #2;
        rst_n = 1;
        sweep("R1 reset");

        for (int i = 0; i < 16; i++)
            do_write("R2 qword", i, 3, 1'b1, {32'hA5A5_0000 + 32'(i), 32'hDEAD_BE00 + 32'(i)});
        do_write("R3 dword", 2, 2, 1'b0, 64'hFFFF_FFFF_1234_5678);
        do_write("R3 dword ext", 12, 2, 1'b1, 64'h0123_4567_89AB_CDEF);
        do_write("R4 word", 3, 1, 1'b0, 64'hFFFF_FFFF_FFFF_BEEF);
        do_write("R5 low byte", 1, 0, 1'b0, 64'hFFFF_FFFF_FFFF_FF5A);
        do_write("R6 high byte 4", 4, 0, 1'b0, 64'h11);
        do_write("R6 high byte 5", 5, 0, 1'b0, 64'h22);
        do_write("R6 high byte 6", 6, 0, 1'b0, 64'h33);
        do_write("R6 high byte 7", 7, 0, 1'b0, 64'h44);
        for (int i = 4; i < 16; i++)
            do_write("R7 ext low byte", i, 0, 1'b1, 64'hC0 + 64'(i));
        do_write("R9 suppressed", 9, 3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        do_write("R9 suppressed byte", 15, 0, 1'b0, 64'h77);

        // R8: read formats on port A for several sizes and aliases
        for (int i = 0; i < 16; i++) begin
            for (int s = 0; s < 4; s++) begin
                for (int e = 0; e < 2; e++) begin
                    ra_idx = 4'(i); ra_size = 2'(s); ra_ext = e[0];
                    #1;
                    check64("R9 ra_illegal", {63'd0, ra_illegal}, {63'd0, (e == 0 && i >= 8)});
                    if (!(e == 0 && i >= 8))
                        check64("R8 read format", ra_data, ref_read(i, s, e[0]));
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule